// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block is a synchronous front end for one asynchronous 2M x 8 page-mode DRAM. A client hands it single-byte requests on a valid/ready port. Each request carries a 21-bit address, a write flag and write data. The controller splits the address into an 11-bit row and a 10-bit column and sends them one after the other over a shared 11-bit address bus. It produces the active-low row strobe, column strobe, write strobe and output-enable, and it steers an 8-bit data bus through a split in/out pair with a drive enable. It returns read bytes on a one-cycle response strobe.

After a request, the row stays open. A later request to the same row costs only a new column cycle. A request to a different row closes the row and precharges before the new row opens. A refresh scheduler inserts column-before-row refresh cycles at a fixed period, which keeps the 2048-refresh-per-32-ms budget. The device supplies the refresh row itself. Every DRAM timing minimum is a nanosecond parameter. It is converted to clock cycles, rounding up, for a parameterised clock period.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` never depends on `req_valid`. While `req_valid` is high, the client keeps the address, flag and data steady until the handshake. Read responses come back in request order, one `rsp_valid` pulse per read, and they cannot be stalled.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, both strobes stay high and `req_ready` stays low for at least the initial pause. Exactly 8 refresh cycles then complete before `req_ready` first rises.
- R2: The row is `req_addr[20:10]` on the address bus when the row strobe falls. The column is `req_addr[9:0]` on bits 9:0 of the bus, with bit 10 low, when the column strobe falls.
- R3: For a write, the write strobe is low at least one cycle before the column strobe falls. The data bus is driven with the write byte and output-enable is high while the column strobe falls.
- R4: For a read, output-enable is low and the bus is not driven when the column strobe falls. `rsp_rdata` returns the byte last written to that address, or the stored content if the address was never written.
- R5: Read data is captured only after the row-access, column-access and address-access times have all elapsed.
- R6: Consecutive accesses to the open row use back-to-back column cycles with no new row activation.
- R7: An access to a different row raises the row strobe and holds it high for at least the precharge time before the new row is opened.
- R8: Successive row-strobe falls are at least the random cycle time apart. Successive column-strobe falls within one open row are at least the page cycle time apart.
- R9: In a refresh, the column strobe falls before the row strobe, the write strobe stays high and `req_ready` is low. Refresh cycles are never more than 15625 ns apart.
- R10: `req_ready` is high only in the idle or row-open state with no refresh waiting. Every accepted read yields exactly one response, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 21 | Byte address, row in 20:10, column in 9:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read byte |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data returned from the DRAM |

## Verification
The bench model returns a poison byte until every access time has passed. An age counter that restarts on the wrong edge or a too-short wait therefore shows up as wrong read data on the very access that violates it. A wrong open-row register or hit decision shows up as extra row activations or corrupted data within a few requests. A stalled refresh timer shows up as a gap check failure after one refresh period. The model also times every strobe edge against its minimum as the edge occurs, so a slip is flagged in the same cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_OPEN,
    ST_CLOSE,
    ST_CBR_CAS,
    ST_CBR_RAS
  } ctl_state_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ROW,
    SEL_COL
  } addr_sel_e;

  // indices into the edge-age counter bank
  localparam int N_AGE  = 5;
  localparam int AG_RF  = 0;  // since row strobe fell
  localparam int AG_RR  = 1;  // since row strobe rose
  localparam int AG_CF  = 2;  // since column strobe fell
  localparam int AG_CR  = 3;  // since column strobe rose
  localparam int AG_COL = 4;  // since column address applied

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/fpm_age.sv
module fpm_age #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);

  // age counts edges since the event, loaded with 1 at the event edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '1;
    else if (restart)      age <= W'(1);
    else if (age != '1)    age <= age + 1'b1;
  end

endmodule

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
  parameter int PAUSE_CYC = 25000,
  parameter int REF_CYC   = 1875,
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic pause_done,
  output logic init_done,
  output logic ref_pend
);

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int RW = $clog2(REF_CYC + 1);
  localparam int IW = $clog2(INIT_REFS + 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] init_left;
  logic [RW-1:0] tick_cnt;
  logic          tick_pend;

  assign pause_done = (pause_cnt == '0);
  assign init_done  = pause_done && (init_left == '0);
  assign ref_pend   = pause_done && ((init_left != '0) || tick_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_cnt <= PW'(PAUSE_CYC);
      init_left <= IW'(INIT_REFS);
      tick_cnt  <= '0;
      tick_pend <= 1'b0;
    end else begin
      if (!pause_done) pause_cnt <= pause_cnt - 1'b1;
      if (ref_ack) begin
        if (init_left != '0) init_left <= init_left - 1'b1;
        else                 tick_pend <= 1'b0;
      end
      if (init_done) begin
        if (tick_cnt == RW'(REF_CYC - 1)) begin
          tick_cnt  <= '0;
          tick_pend <= 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  // R9
  ack_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> ref_pend);

endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux
  import fpm_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 10
) (
  input  addr_sel_e                sel,
  input  logic [ROW_W+COL_W-1:0]   addr,
  output logic [ROW_W-1:0]         dram_a
);

  always_comb begin
    case (sel)
      SEL_ROW: dram_a = addr[ROW_W+COL_W-1:COL_W];
      SEL_COL: dram_a = ROW_W'(addr[COL_W-1:0]);
      default: dram_a = '0;
    endcase
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int CLK_NS        = 8,
  parameter int ROW_W         = 11,
  parameter int COL_W         = 10,
  parameter int DQ_W          = 8,
  parameter int AGE_W         = 8,
  parameter int T_RC_NS       = 84,
  parameter int T_RAS_NS      = 50,
  parameter int T_RP_NS       = 30,
  parameter int T_RCD_NS      = 20,
  parameter int T_RAC_NS      = 50,
  parameter int T_CAC_NS      = 13,
  parameter int T_AA_NS       = 25,
  parameter int T_PC_NS       = 35,
  parameter int T_CP_NS       = 10,
  parameter int T_CAS_NS      = 13,
  parameter int T_CSR_NS      = 10,
  parameter int T_ASC_NS      = 1,
  parameter int REF_NS        = 15000,
  parameter int INIT_PAUSE_NS = 200000,
  parameter int INIT_REFS     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic [ROW_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);

  localparam int AW = ROW_W + COL_W;

  localparam logic [AGE_W-1:0] C_RC  = AGE_W'(ns_to_cyc(T_RC_NS,  CLK_NS));
  localparam logic [AGE_W-1:0] C_RAS = AGE_W'(ns_to_cyc(T_RAS_NS, CLK_NS));
  localparam logic [AGE_W-1:0] C_RP  = AGE_W'(ns_to_cyc(T_RP_NS,  CLK_NS));
  localparam logic [AGE_W-1:0] C_RCD = AGE_W'(ns_to_cyc(T_RCD_NS, CLK_NS));
  localparam logic [AGE_W-1:0] C_RAC = AGE_W'(ns_to_cyc(T_RAC_NS, CLK_NS));
  localparam logic [AGE_W-1:0] C_CAC = AGE_W'(ns_to_cyc(T_CAC_NS, CLK_NS));
  localparam logic [AGE_W-1:0] C_AA  = AGE_W'(ns_to_cyc(T_AA_NS,  CLK_NS));
  localparam logic [AGE_W-1:0] C_PC  = AGE_W'(ns_to_cyc(T_PC_NS,  CLK_NS));
  localparam logic [AGE_W-1:0] C_CP  = AGE_W'(ns_to_cyc(T_CP_NS,  CLK_NS));
  localparam logic [AGE_W-1:0] C_CAS = AGE_W'(ns_to_cyc(T_CAS_NS, CLK_NS));
  localparam logic [AGE_W-1:0] C_CSR = AGE_W'(ns_to_cyc(T_CSR_NS, CLK_NS));
  localparam logic [AGE_W-1:0] C_ASC = AGE_W'(ns_to_cyc(T_ASC_NS, CLK_NS));
  localparam int PAUSE_CYC = ns_to_cyc(INIT_PAUSE_NS, CLK_NS);
  localparam int REF_CYC   = ns_to_cyc(REF_NS, CLK_NS);

  ctl_state_e st_q, st_d;
  addr_sel_e  sel_q, sel_d;
  logic ras_q, ras_d, cas_q, cas_d, we_q, we_d, oe_q, oe_d, dqoe_q, dqoe_d;
  logic hold_q, hold_d, rsp_v_q, rsp_v_d;
  logic [DQ_W-1:0] rdata_q, rdata_d;
  logic [AW-1:0]   rq_addr;
  logic            rq_we;
  logic [DQ_W-1:0] rq_wd;

  logic pause_done, init_done, ref_pend, ref_ack;
  logic accept, row_hit, ras_gap_ok, cas_gap_ok, cas_done;

  logic [N_AGE-1:0] age_rst;
  logic [AGE_W-1:0] ages [N_AGE];

  // ---------------- edge-age counters ----------------
  generate
    for (genvar gi = 0; gi < N_AGE; gi++) begin : g_age
      fpm_age #(.W(AGE_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (age_rst[gi]),
        .age     (ages[gi])
      );
    end
  endgenerate

  always_comb begin
    age_rst         = '0;
    age_rst[AG_RF]  = ras_q & ~ras_d;
    age_rst[AG_RR]  = ~ras_q & ras_d;
    age_rst[AG_CF]  = cas_q & ~cas_d;
    age_rst[AG_CR]  = ~cas_q & cas_d;
    age_rst[AG_COL] = (st_d == ST_COL) && (st_q != ST_COL);
  end

  // ---------------- refresh and init pacing ----------------
  fpm_refresh_sched #(
    .PAUSE_CYC (PAUSE_CYC),
    .REF_CYC   (REF_CYC),
    .INIT_REFS (INIT_REFS)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_ack    (ref_ack),
    .pause_done (pause_done),
    .init_done  (init_done),
    .ref_pend   (ref_pend)
  );

  // ---------------- request port ----------------
  assign req_ready = init_done && !ref_pend && ((st_q == ST_IDLE) || (st_q == ST_OPEN));
  assign accept    = req_valid && req_ready;
  assign row_hit   = (req_addr[AW-1:COL_W] == rq_addr[AW-1:COL_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_addr <= '0;
      rq_we   <= 1'b0;
      rq_wd   <= '0;
    end else if (accept) begin
      rq_addr <= req_addr;
      rq_we   <= req_we;
      rq_wd   <= req_wdata;
    end
  end

  // ---------------- timing gates ----------------
  assign ras_gap_ok = (ages[AG_RR] >= C_RP) && (ages[AG_RF] >= C_RC);
  assign cas_gap_ok = (ages[AG_CR] >= C_CP) && (ages[AG_CF] >= C_PC) &&
                      (ages[AG_COL] >= C_ASC);
  assign cas_done   = (ages[AG_CF] >= C_CAS) &&
                      (rq_we || ((ages[AG_RF] >= C_RAC) && (ages[AG_CF] >= C_CAC) &&
                                 (ages[AG_COL] >= C_AA)));

  // ---------------- sequencer ----------------
  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    ras_d   = ras_q;
    cas_d   = cas_q;
    we_d    = we_q;
    oe_d    = oe_q;
    dqoe_d  = dqoe_q;
    hold_d  = hold_q;
    rsp_v_d = 1'b0;
    rdata_d = rdata_q;
    ref_ack = 1'b0;
    case (st_q)
      ST_PAUSE: if (pause_done) st_d = ST_IDLE;
      ST_IDLE: begin
        if (ref_pend) begin
          if (ras_gap_ok && (ages[AG_CR] >= C_CP)) begin
            cas_d = 1'b0;
            st_d  = ST_CBR_CAS;
          end
        end else if (accept) begin
          sel_d = SEL_ROW;
          st_d  = ST_ROW;
        end
      end
      ST_ROW: if (ras_gap_ok) begin
        ras_d = 1'b0;
        st_d  = ST_RCD;
      end
      ST_RCD: if (ages[AG_RF] >= C_RCD) begin
        sel_d  = SEL_COL;
        we_d   = !rq_we;
        oe_d   = rq_we;
        dqoe_d = rq_we;
        st_d   = ST_COL;
      end
      ST_COL: if (cas_gap_ok) begin
        cas_d = 1'b0;
        st_d  = ST_CAS;
      end
      ST_CAS: if (cas_done) begin
        cas_d  = 1'b1;
        we_d   = 1'b1;
        oe_d   = 1'b1;
        dqoe_d = 1'b0;
        st_d   = ST_OPEN;
        if (!rq_we) begin
          rsp_v_d = 1'b1;
          rdata_d = dram_dq_in;
        end
      end
      ST_OPEN: begin
        if (ref_pend) begin
          st_d = ST_CLOSE;
        end else if (accept) begin
          if (row_hit) begin
            sel_d  = SEL_COL;
            we_d   = !req_we;
            oe_d   = req_we;
            dqoe_d = req_we;
            st_d   = ST_COL;
          end else begin
            hold_d = 1'b1;
            st_d   = ST_CLOSE;
          end
        end
      end
      ST_CLOSE: if (ages[AG_RF] >= C_RAS) begin
        ras_d = 1'b1;
        if (hold_q) begin
          hold_d = 1'b0;
          sel_d  = SEL_ROW;
          st_d   = ST_ROW;
        end else begin
          sel_d = SEL_NONE;
          st_d  = ST_IDLE;
        end
      end
      ST_CBR_CAS: if (ages[AG_CF] >= C_CSR) begin
        ras_d = 1'b0;
        st_d  = ST_CBR_RAS;
      end
      ST_CBR_RAS: if (ages[AG_RF] >= C_RAS) begin
        ras_d   = 1'b1;
        cas_d   = 1'b1;
        ref_ack = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PAUSE;
      sel_q   <= SEL_NONE;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      hold_q  <= 1'b0;
      rsp_v_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      dqoe_q  <= dqoe_d;
      hold_q  <= hold_d;
      rsp_v_q <= rsp_v_d;
      rdata_q <= rdata_d;
    end
  end

  fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
    .sel    (sel_q),
    .addr   (rq_addr),
    .dram_a (dram_a)
  );

  assign dram_ras_n  = ras_q;
  assign dram_cas_n  = cas_q;
  assign dram_we_n   = we_q;
  assign dram_oe_n   = oe_q;
  assign dram_dq_oe  = dqoe_q;
  assign dram_dq_out = rq_wd;
  assign rsp_valid   = rsp_v_q;
  assign rsp_rdata   = rdata_q;

  // ---------------- assertions ----------------
  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe));

  // R9
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

  // R7
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ($past(ages[AG_RR]) >= C_RP));

  // R10
  ready_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_pend);

  // R1
  init_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);

  // R4
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_dq_oe && !dram_oe_n));

endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  PAUSE_NS = 2000;
  localparam int  REF_CYC  = 1875;
  localparam longint T_RC = 84, T_RP = 30, T_PC = 35, T_RAC = 50, T_CAC = 13, T_AA = 25;
  localparam longint REF_BUDGET = 15625;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we;
  logic [20:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [10:0] dram_a;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0]  dram_dq_out, dq_drv;

  fpm_dram_ctrl #(.INIT_PAUSE_NS(PAUSE_NS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_drv)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] fill(input logic [20:0] k);
    return k[7:0] ^ k[15:8] ^ {3'b000, k[20:16]} ^ 8'h5A;
  endfunction

  // ---------------- DRAM model ----------------
  logic [7:0] dmem [logic [20:0]];
  logic [7:0] emem [logic [20:0]];
  logic [7:0] expq [$];

  longint t_rel = 0, t_rf = -100000, t_rr = -100000, t_cf = -100000;
  longint t_cfp = -100000, t_ach = 0, t_cbr = -1;
  bit     prev_ras = 1, prev_cas = 1, rd_act = 0, first_seen = 0;
  logic [10:0] prev_a = '0, cur_row = '0;
  logic [20:0] rd_key = '0;
  int acts = 0, refs = 0, resps = 0, reads_issued = 0;

  initial dq_drv = 8'hEE;

  always @(negedge clk) begin
    longint now;
    now = longint'($time);
    if (rst_n) begin
      if (dram_a != prev_a) t_ach = now;
      if (!first_seen && (!dram_ras_n || !dram_cas_n)) begin
        first_seen = 1;
        check(now - t_rel >= PAUSE_NS, "R1 pause before first strobe", now - t_rel, PAUSE_NS);
      end
      if (prev_ras && !dram_ras_n) begin
        check(now - t_rf >= T_RC, "R8 row cycle time", now - t_rf, T_RC);
        check(now - t_rr >= T_RP, "R7 precharge time", now - t_rr, T_RP);
        if (!dram_cas_n) begin
          check(!prev_cas && dram_we_n, "R9 refresh strobe order", {prev_cas, dram_we_n}, 2'b01);
          check(!req_ready, "R9 ready low in refresh", req_ready, 0);
          refs++;
          if (refs > 8 && t_cbr >= 0)
            check(now - t_cbr <= REF_BUDGET, "R9 refresh gap", now - t_cbr, REF_BUDGET);
          t_cbr = now;
        end else begin
          acts++;
          cur_row = dram_a;
          t_cfp = -100000;
        end
        t_rf = now;
      end
      if (!prev_ras && dram_ras_n) begin
        t_rr = now;
        rd_act = 0;
      end
      if (prev_cas && !dram_cas_n && !dram_ras_n) begin
        check(dram_a[10] == 1'b0, "R2 column bit 10 low", dram_a[10], 0);
        check(now - t_cfp >= T_PC, "R8 page cycle time", now - t_cfp, T_PC);
        t_cfp = now;
        t_cf  = now;
        if (!dram_we_n) begin
          check(dram_dq_oe && dram_oe_n, "R3 write bus state", {dram_dq_oe, dram_oe_n}, 2'b11);
          dmem[{cur_row, dram_a[9:0]}] = dram_dq_out;
          rd_act = 0;
        end else begin
          check(!dram_dq_oe && !dram_oe_n, "R4 read bus state", {dram_dq_oe, dram_oe_n}, 2'b00);
          rd_act = 1;
          rd_key = {cur_row, dram_a[9:0]};
        end
      end
      if (!prev_cas && dram_cas_n) rd_act = 0;
      if (prev_cas && !dram_cas_n && dram_ras_n) t_cf = now;
      if (rd_act && !dram_cas_n &&
          (now - t_rf + 8 >= T_RAC) && (now - t_cf + 8 >= T_CAC) && (now - t_ach + 8 >= T_AA))
        dq_drv = dmem.exists(rd_key) ? dmem[rd_key] : fill(rd_key);
      else
        dq_drv = 8'hEE;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_a   = dram_a;
    end
  end

  // ---------------- response monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      resps++;
      if (expq.size() == 0) begin
        check(0, "R10 response without read", 1, 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(rsp_rdata == e, "R4 R5 read data", rsp_rdata, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [20:0] a, input bit w, input logic [7:0] d);
    req_valid = 1'b1;
    req_addr  = a;
    req_we    = w;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (w) emem[a] = d;
    else begin
      expq.push_back(emem.exists(a) ? emem[a] : fill(a));
      reads_issued++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int a0, r0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    check(dram_ras_n && dram_cas_n && !req_ready && !rsp_valid && !dram_dq_oe,
          "R1 reset outputs", {dram_ras_n, dram_cas_n, req_ready, rsp_valid, dram_dq_oe}, 5'b11000);
    rst_n = 1'b1;
    t_rel = longint'($time);
    while (!req_ready) @(negedge clk);
    check(refs == 8, "R1 initial refresh count", refs, 8);

    // page hits, then row boundary
    a0 = acts; r0 = refs;
    for (int i = 0; i < 4; i++) issue({11'd5, 10'(i * 3)}, 1'b1, 8'(8'hA0 + i));
    for (int i = 0; i < 4; i++) issue({11'd5, 10'(i * 3)}, 1'b0, 8'h00);
    drain();
    check((acts - a0) >= 1 && (acts - a0) <= 1 + (refs - r0), "R6 single activation for hits",
          acts - a0, 1);

    a0 = acts;
    issue({11'd7, 10'd3}, 1'b0, 8'h00);
    issue({11'd9, 10'd3}, 1'b0, 8'h00);
    issue({11'd7, 10'd3}, 1'b0, 8'h00);
    issue({11'd9, 10'd3}, 1'b0, 8'h00);
    drain();
    check((acts - a0) >= 4, "R7 activation per row change", acts - a0, 4);

    // address corners
    issue(21'h1FFFFF, 1'b1, 8'h3C);
    issue(21'h000000, 1'b1, 8'hC3);
    issue(21'h1FFFFF, 1'b0, 8'h00);
    issue(21'h000000, 1'b0, 8'h00);
    issue(21'h0FFC00, 1'b0, 8'h00);
    issue(21'h1003FF, 1'b0, 8'h00);
    drain();

    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1200; i++) begin
      logic [10:0] row;
      logic [9:0]  col;
      row = 11'($urandom % 6) * 11'd341;
      col = 10'($urandom % 1024);
      issue({row, col}, 1'($urandom % 2), 8'($urandom));
      if (($urandom % 8) == 0) repeat (1 + ($urandom % 12)) @(negedge clk);
    end
    drain();
    check(expq.size() == 0 && resps == reads_issued, "R10 one response per read",
          resps, reads_issued);

    // idle refresh
    r0 = refs;
    repeat (2 * REF_CYC + 200) @(negedge clk);
    check((refs - r0) >= 2, "R9 refresh while idle", refs - r0, 2);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R10 actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

endmodule